// File: doc/BRIEF.md
# Register Access Slave over SPI

This block is the serial front end of a small control register bank. An external SPI master reaches up to 32 byte-wide registers with fixed 16-bit frames. While chip select is low, the master sends three things in order: a direction flag, an address field and then a data byte. The block turns each frame into a single access on a simple register-file port. That port carries an address, a write strobe with its write data, and a read strobe with read data returned in the same cycle. Address zero is expected to be a queue: a read strobe there pops one receive entry and a write strobe pushes one transmit entry. Because of this, every strobe fires at most once per frame.

The bus runs in SPI mode 0. MOSI is sampled on rising SCK and MISO changes after falling SCK. The SCK, chip select and MOSI inputs are assumed to be already synchronous to `clk`, and the block finds SCK edges by oversampling them. SCK must stay high for at least three `clk` cycles and low for at least three `clk` cycles. On a read, the register is fetched as soon as the header byte is complete, so its value leaves on MISO during the second byte of the same frame.

Top module: `spi_reg_slave`

## Requirements
- R1: A frame is 16 bits sent MSB first. A bit is taken on each rising SCK edge seen while spi_cs_n is low. Frame bit 15 is the direction flag. Bits 14:8 form a 7-bit address field, and bits 7:0 are the data byte.
- R2: When the direction flag is 1 (write) and the 16th rising edge arrives with spi_cs_n still low, reg_wr_en pulses once. In that cycle reg_addr equals address field bits 4:0 and reg_wr_data equals frame bits 7:0.
- R3: When the direction flag is 0 (read), reg_rd_en pulses exactly once per frame, right after the 8th rising edge, with reg_addr set to the frame's address.
- R4: On a read, the value on reg_rd_data in the reg_rd_en cycle is shifted out on spi_miso MSB first. One bit is sent per falling SCK edge, starting with the falling edge that follows the 8th rising edge. The master therefore reads it on rising edges 9 to 16.
- R5: spi_miso is low during the whole first byte of every frame, during the whole of a write frame, and while spi_cs_n is high.
- R6: An address field above 0x1F (bits 14:13 not both zero) causes no strobe of either kind. A read of such an address returns 0x00 on spi_miso.
- R7: If spi_cs_n rises before the 16th bit, no write strobe is issued. The next frame starts again from its first bit.
- R8: Rising edges after the 16th within one chip-select period are ignored and cause no further strobe.
- R9: reg_wr_en and reg_rd_en are never high together, and each stays high for one cycle only.
- R10: After reset, reg_wr_en, reg_rd_en and spi_miso are low.
- R11: spi_miso changes only in the cycle after a sampled falling SCK edge, or after spi_cs_n was sampled high.
- R12: reg_addr keeps its value from the end of the header until the write strobe of the same frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low, synchronous to clk |
| spi_sck | input | 1 | Serial clock, idle low, synchronous to clk |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| reg_addr | output | ADDR_W (5) | Register address |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | DATA_W (8) | Write data, valid with reg_wr_en |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rd_data | input | DATA_W (8) | Read data, must be valid in the reg_rd_en cycle |

## Verification
Writes and read-backs use values with a single high bit, a single low bit, all ones, and the top legal address. These show whether the bit order and the address slice are correct. Three reads of address zero from a preloaded queue must return its entries in order, which shows whether a frame pops once or more than once. An address above 0x1F whose low bits alias a live register shows whether the range check exists. Frames cut short at 10 and 15 bits, and a frame stretched to 20 bits, separate strobing on the 16th edge from strobing on the edge count alone.

// File: rtl/spi_reg_slave_pkg.sv
package spi_reg_slave_pkg;

    // Encoding of the frame's top bit
    typedef enum logic {
        DIR_READ  = 1'b0,
        DIR_WRITE = 1'b1
    } spi_dir_e;

endpackage

// File: rtl/spi_sck_edge.sv
// Oversamples SCK with clk and flags edges while the slave is selected.
module spi_sck_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sck,
    output logic sel,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic sck;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.sck = sck;
        sel      = ~cs_n;
        rise     = ~cs_n & sck & ~st_q.sck;
        fall     = ~cs_n & ~sck & st_q.sck;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/spi_frame_rx.sv
// Receives a frame, decodes the header and issues register strobes.
module spi_frame_rx
    import spi_reg_slave_pkg::*;
#(
    parameter int ADDR_W  = 5,
    parameter int FIELD_W = 7,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rise,
    input  logic              mosi,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_en
);
    localparam int HDR_W   = 1 + FIELD_W;
    localparam int FRAME_W = HDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] HDR_LAST   = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] FRAME_END  = CNT_W'(FRAME_W);

    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-2:0] shreg;
        logic               is_write;
        logic               in_range;
        logic [ADDR_W-1:0]  addr;
        logic               wr_en;
        logic [DATA_W-1:0]  wr_data;
        logic               rd_en;
    } rx_state_t;

    rx_state_t st_d, st_q;
    logic [HDR_W-1:0] hdr;
    logic             hdr_ok;

    always_comb begin
        st_d       = st_q;
        st_d.wr_en = 1'b0;
        st_d.rd_en = 1'b0;
        hdr        = {st_q.shreg[HDR_W-2:0], mosi};
        hdr_ok     = ((hdr[FIELD_W-1:0] >> ADDR_W) == '0);

        if (!sel) begin
            st_d.cnt = '0;
        end else if (rise && (st_q.cnt < FRAME_END)) begin
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.shreg = {st_q.shreg[FRAME_W-3:0], mosi};

            if (st_q.cnt == HDR_LAST) begin
                st_d.is_write = (hdr[HDR_W-1] == DIR_WRITE);
                st_d.in_range = hdr_ok;
                if (hdr_ok) begin
                    st_d.addr = hdr[ADDR_W-1:0];
                end
                st_d.rd_en = (hdr[HDR_W-1] == DIR_READ) && hdr_ok;
            end

            if (st_q.cnt == FRAME_LAST && st_q.is_write && st_q.in_range) begin
                st_d.wr_en   = 1'b1;
                st_d.wr_data = {st_q.shreg[DATA_W-2:0], mosi};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign addr    = st_q.addr;
    assign wr_en   = st_q.wr_en;
    assign wr_data = st_q.wr_data;
    assign rd_en   = st_q.rd_en;
endmodule

// File: rtl/spi_miso_tx.sv
// Holds the read byte and shifts it out after each falling SCK edge.
module spi_miso_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              fall,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              miso
);
    typedef struct packed {
        logic [DATA_W-1:0] tx;
        logic              miso;
    } tx_state_t;

    tx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!sel) begin
            st_d.tx   = '0;
            st_d.miso = 1'b0;
        end else if (load) begin
            st_d.tx = load_data;
        end else if (fall) begin
            st_d.miso = st_q.tx[DATA_W-1];
            st_d.tx   = {st_q.tx[DATA_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miso = st_q.miso;
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave #(
    parameter int ADDR_W  = 5,
    parameter int FIELD_W = 7,
    parameter int DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              reg_rd_en,
    input  logic [DATA_W-1:0] reg_rd_data
);
    logic sel;
    logic sck_rise;
    logic sck_fall;

    spi_sck_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (spi_cs_n),
        .sck   (spi_sck),
        .sel   (sel),
        .rise  (sck_rise),
        .fall  (sck_fall)
    );

    spi_frame_rx #(
        .ADDR_W  (ADDR_W),
        .FIELD_W (FIELD_W),
        .DATA_W  (DATA_W)
    ) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .rise    (sck_rise),
        .mosi    (spi_mosi),
        .addr    (reg_addr),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .rd_en   (reg_rd_en)
    );

    // The read strobe cycle is the capture cycle for reg_rd_data
    spi_miso_tx #(
        .DATA_W (DATA_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .fall      (sck_fall),
        .load      (reg_rd_en),
        .load_data (reg_rd_data),
        .miso      (spi_miso)
    );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk #(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              spi_cs_n,
    input logic              spi_sck,
    input logic              spi_miso,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr_en,
    input logic              reg_rd_en
);
    assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_en && reg_rd_en));

    assert_wr_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |=> !reg_wr_en);

    assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd_en |=> !reg_rd_en);

    assert_no_strobe_deselected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(spi_cs_n) |-> (!reg_wr_en && !reg_rd_en));

    assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $stable(reg_addr));

    assert_miso_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(spi_sck) && !$past(spi_cs_n)) |-> $stable(spi_miso));

    assert_miso_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |=> !spi_miso);
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .spi_miso  (spi_miso),
    .reg_addr  (reg_addr),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en)
);

// File: tb/spi_reg_slave_tb.sv
module spi_reg_slave_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       spi_cs_n, spi_sck, spi_mosi;
    logic       spi_miso;
    logic [4:0] reg_addr;
    logic       reg_wr_en, reg_rd_en;
    logic [7:0] reg_wr_data, reg_rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spi_reg_slave u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .spi_cs_n    (spi_cs_n),
        .spi_sck     (spi_sck),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_en   (reg_rd_en),
        .reg_rd_data (reg_rd_data)
    );

    // Register bank model: address 0 is a pop/push queue pair
    logic [7:0] regmem [32];
    logic [7:0] rxq [4];
    int         rxq_rd = 0;
    logic [7:0] txq [4];
    int         txq_n = 0;

    initial begin
        for (int i = 0; i < 32; i++) regmem[i] = 8'h00;
        rxq[0] = 8'h11; rxq[1] = 8'h22; rxq[2] = 8'h33; rxq[3] = 8'h00;
    end

    always_comb begin
        if (reg_addr == 5'd0) reg_rd_data = (rxq_rd < 4) ? rxq[rxq_rd] : 8'h00;
        else                  reg_rd_data = regmem[reg_addr];
    end

    always @(posedge clk) begin
        if (reg_wr_en) begin
            if (reg_addr == 5'd0) begin
                if (txq_n < 4) txq[txq_n] <= reg_wr_data;
                txq_n <= txq_n + 1;
            end else begin
                regmem[reg_addr] <= reg_wr_data;
            end
        end
        if (reg_rd_en && reg_addr == 5'd0) rxq_rd <= rxq_rd + 1;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Scoreboard of expected strobes
    typedef struct {
        bit         is_wr;
        logic [4:0] a;
        logic [7:0] d;
        string      req;
    } exp_t;
    exp_t sbq[$];

    always @(negedge clk) begin
        if (rst_n && (reg_wr_en || reg_rd_en)) begin
            check(!(reg_wr_en && reg_rd_en), "R9", "both strobes", {reg_wr_en, reg_rd_en}, 16'h0);
            if (sbq.size() == 0) begin
                check(1'b0, "R6/R7/R8", "unexpected strobe addr", {11'h0, reg_addr}, 16'h0);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(e.is_wr == reg_wr_en, e.req, "strobe kind", {15'h0, reg_wr_en}, {15'h0, e.is_wr});
                check(e.a == reg_addr, e.req, "strobe addr", {11'h0, reg_addr}, {11'h0, e.a});
                if (e.is_wr)
                    check(e.d == reg_wr_data, e.req, "write data", {8'h0, reg_wr_data}, {8'h0, e.d});
            end
        end
    end

    task automatic spi_frame(input logic [15:0] word, input int nbits, output logic [15:0] got);
        got = 16'h0;
        spi_cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = (i < 16) ? word[15-i] : 1'b1;
            repeat (4) @(negedge clk);
            if (i < 16) got[15-i] = spi_miso;
            spi_sck = 1'b1;
            repeat (4) @(negedge clk);
            spi_sck = 1'b0;
        end
        repeat (4) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] d, input int nbits, input string req);
        logic [15:0] got;
        if (a < 7'h20 && nbits >= 16) sbq.push_back('{1'b1, a[4:0], d, req});
        spi_frame({1'b1, a, d}, nbits, got);
        check(got == 16'h0, "R5", "miso during write", got, 16'h0);
        check(sbq.size() == 0, req, "strobes pending", 16'(sbq.size()), 16'h0);
        sbq.delete();
    endtask

    task automatic do_read(input logic [6:0] a, input logic [7:0] exp, input string req);
        logic [15:0] got;
        if (a < 7'h20) sbq.push_back('{1'b0, a[4:0], 8'h00, req});
        spi_frame({1'b0, a, 8'h00}, 16, got);
        check(got[15:8] == 8'h0, "R5", "miso first byte", {8'h0, got[15:8]}, 16'h0);
        check(got[7:0] == exp, "R4", "read byte", {8'h0, got[7:0]}, {8'h0, exp});
        check(sbq.size() == 0, req, "strobes pending", 16'(sbq.size()), 16'h0);
        sbq.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", "timeout", 16'h0, 16'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; spi_cs_n = 1'b1; spi_sck = 1'b0; spi_mosi = 1'b0;
        repeat (5) @(negedge clk);
        check(!reg_wr_en && !reg_rd_en && !spi_miso, "R10", "reset outputs",
              {13'h0, reg_wr_en, reg_rd_en, spi_miso}, 16'h0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 R2 R4: bit order and basic access
        do_write(7'h05, 8'hA5, 16, "R2");
        do_read (7'h05, 8'hA5, "R3");
        do_write(7'h1F, 8'h3C, 16, "R2");
        do_read (7'h1F, 8'h3C, "R1");
        do_write(7'h01, 8'h80, 16, "R2");
        do_write(7'h02, 8'h01, 16, "R2");
        do_write(7'h0A, 8'hFF, 16, "R2");
        do_read (7'h01, 8'h80, "R4");
        do_read (7'h02, 8'h01, "R4");
        do_read (7'h0A, 8'hFF, "R4");

        // R3: queue at address 0 pops once per read frame
        do_read(7'h00, 8'h11, "R3");
        do_read(7'h00, 8'h22, "R3");
        do_read(7'h00, 8'h33, "R3");
        do_write(7'h00, 8'h5E, 16, "R2");
        check(txq_n == 1 && txq[0] == 8'h5E, "R2", "push to tx queue", {txq[0], 8'(txq_n)}, 16'h5E01);

        // R6: out-of-range address aliasing register 5
        do_write(7'h25, 8'hFF, 16, "R6");
        do_read (7'h25, 8'h00, "R6");
        do_read (7'h05, 8'hA5, "R6");

        // R7: aborted writes
        do_write(7'h05, 8'h00, 10, "R7");
        do_write(7'h05, 8'h00, 15, "R7");
        do_read (7'h05, 8'hA5, "R7");

        // R8: stretched frame
        do_write(7'h06, 8'h77, 20, "R8");
        do_read (7'h06, 8'h77, "R8");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule